// File: doc/BRIEF.md
# Four-bit accumulator execute unit

This block is the execute stage of a small 4-bit accumulator machine. Each cycle in which `valid_i` is high it takes one 8-bit word. That word is either a complete one-word instruction or part of a two-word immediate instruction. The block computes the result from three sources: the accumulator, the data-memory nibble that an external data pointer selects (`mem_rdata_i`), and the carry flag. It then updates the accumulator and the carry flag. When the instruction asks for it, the block also issues a memory write of the result.

Memory-operand instructions exist in pairs. The plain form writes only the accumulator. The write-back form also stores the result into the addressed memory nibble. The instruction set also has immediate arithmetic and logic, single-bit shifts with a selectable fill bit, and memory increment and decrement. A `done_o` pulse marks the cycle in which the results of a finished instruction are visible on the outputs.

Top module: `nib_exec_unit`

## Requirements
- R1: While `rst_ni` is low, and after it is released, the accumulator and the carry flag read 0, `done_o` is 0, `mem_we_o` is 0, and no immediate instruction is pending. A first word left waiting at reset is therefore discarded.
- R2: Word `1000_0ooo` is a memory-operand operation whose result goes to the accumulator only, with no memory write. The 3-bit field ooo selects: 0 add-with-carry, 1 subtract-with-carry, 2 add, 3 subtract, 4 add without carry update, 5 AND, 6 XOR, 7 OR.
- R3: Word `1000_1ooo` performs the same operation as R2, with the same ooo encoding. The result is written to the accumulator, and `mem_we_o` pulses together with `done_o`, carrying `mem_wdata_o` equal to the new accumulator.
- R4: Add-with-carry computes A+B+C. Add computes A+B. Subtract computes A+~B+1. Subtract-with-carry computes A+~B+C. All four load the carry flag with the carry out of bit 3, so for subtraction 1 means no borrow.
- R5: Add without carry update, AND, XOR and OR leave the carry flag unchanged.
- R6: Word `1001_0ooo` starts a two-word immediate operation, with the same ooo encoding as R2. The next valid word supplies the operand in its low nibble, and its high nibble is ignored. `done_o` stays low after the first word. No memory write occurs.
- R7: Words `0001_10LF` shift the accumulator by one bit: L=0 shifts right with F entering bit 3, and L=1 shifts left with F entering bit 0. The bit shifted out is lost, and the carry flag is unchanged.
- R8: Word `1001_1000` increments the memory nibble and `1001_1001` decrements it, both modulo 16. The result goes to the accumulator and to memory. The carry flag is unchanged.
- R9: `done_o` is high for the one cycle after the final word of an instruction is consumed. Accumulator, carry, `mem_we_o` and `mem_wdata_o` change only in that cycle.
- R10: Any other word, taken as a first word, changes neither the accumulator nor the carry flag and writes no memory, but it still produces a `done_o` pulse.
- R11: A cycle with `valid_i` low consumes nothing and produces no `done_o` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | `word_i` holds a word to consume this cycle |
| word_i | input | 8 | Opcode word, or the immediate word of a two-word instruction |
| mem_rdata_i | input | 4 | Memory nibble addressed by the data pointer |
| mem_we_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 4 | Memory write data |
| acc_o | output | 4 | Accumulator |
| carry_o | output | 1 | Carry flag |
| done_o | output | 1 | Instruction completed, results visible |

## Verification
On every cycle, the assertions check that a memory write occurs only in a completion cycle and carries the accumulator's new value. They also check that the accumulator and the carry never move outside a completion cycle, that no completion is reported while an immediate operand is awaited, and that an idle cycle is never followed by a completion. Only the bench's scenarios can show that each opcode computes the right value and carry. The same holds for the fill bit of a shift, wrap-around at increment and decrement, the inertness of undefined words, the ignored high nibble of an immediate word, and the loss of a pending first word at reset.

// File: rtl/nib_pkg.sv
package nib_pkg;
  localparam int unsigned OPW = 8;

  typedef enum logic [2:0] {
    OP_ADC = 3'd0, OP_SBC = 3'd1, OP_ADD = 3'd2, OP_SUB = 3'd3,
    OP_ADN = 3'd4, OP_AND = 3'd5, OP_XOR = 3'd6, OP_OR  = 3'd7
  } alu_op_e;

  typedef enum logic [2:0] {
    K_NONE, K_MEM, K_IMM, K_SHIFT, K_STEP
  } kind_e;

  typedef struct packed {
    kind_e   kind;
    alu_op_e op;
    logic    wb;
    logic    sh_left;
    logic    fill;
    logic    step_dn;
  } uop_t;
endpackage

// File: rtl/nib_decode.sv
module nib_decode
  import nib_pkg::*;
(
  input  logic [OPW-1:0] word_i,
  output uop_t           uop_o
);
  always_comb begin
    uop_o      = '0;
    uop_o.kind = K_NONE;
    uop_o.op   = alu_op_e'(word_i[2:0]);
    case (word_i[7:4])
      4'h8: begin
        uop_o.kind = K_MEM;
        uop_o.wb   = word_i[3];
      end
      4'h9: begin
        if (!word_i[3]) begin
          uop_o.kind = K_IMM;
        end else if (word_i[2:1] == 2'b00) begin
          uop_o.kind    = K_STEP;
          uop_o.step_dn = word_i[0];
        end
      end
      4'h1: begin
        if (word_i[3:2] == 2'b10) begin
          uop_o.kind    = K_SHIFT;
          uop_o.sh_left = word_i[1];
          uop_o.fill    = word_i[0];
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/nib_alu.sv
module nib_alu
  import nib_pkg::*;
#(
  parameter int unsigned DW = 4
) (
  input  alu_op_e       op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          c_i,
  output logic [DW-1:0] res_o,
  output logic          cout_o,
  output logic          cupd_o
);
  logic          sub;
  logic          cin;
  logic [DW-1:0] b_eff;
  logic [DW:0]   sum;

  always_comb begin
    sub = (op_i == OP_SBC) || (op_i == OP_SUB);
    case (op_i)
      OP_ADC, OP_SBC: cin = c_i;
      OP_SUB:         cin = 1'b1;
      default:        cin = 1'b0;
    endcase
    b_eff = sub ? ~b_i : b_i;
    sum   = {1'b0, a_i} + {1'b0, b_eff} + {{DW{1'b0}}, cin};
    case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_OR:   res_o = a_i | b_i;
      default: res_o = sum[DW-1:0];
    endcase
    cout_o = sum[DW];
    cupd_o = (op_i == OP_ADC) || (op_i == OP_SBC) ||
             (op_i == OP_ADD) || (op_i == OP_SUB);
  end
endmodule

// File: rtl/nib_unary.sv
module nib_unary #(
  parameter int unsigned DW = 4
) (
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] mem_i,
  input  logic          left_i,
  input  logic          fill_i,
  input  logic          dn_i,
  output logic [DW-1:0] shift_o,
  output logic [DW-1:0] step_o
);
  localparam logic [DW-1:0] ONE = DW'(1);
  localparam int unsigned   MSB = DW - 1;

  logic [DW-1:0] shl, shr;

  // one-bit shifts, lost bit dropped
  for (genvar i = 0; i < DW; i++) begin : g_sh
    if (i == 0) begin : g_lo
      assign shl[i] = fill_i;
    end else begin : g_lo_n
      assign shl[i] = acc_i[i-1];
    end
    if (i == MSB) begin : g_hi
      assign shr[i] = fill_i;
    end else begin : g_hi_n
      assign shr[i] = acc_i[i+1];
    end
  end

  assign shift_o = left_i ? shl : shr;
  assign step_o  = dn_i ? (mem_i - ONE) : (mem_i + ONE);
endmodule

// File: rtl/nib_exec_unit.sv
module nib_exec_unit
  import nib_pkg::*;
#(
  parameter int unsigned DW = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           valid_i,
  input  logic [OPW-1:0] word_i,
  input  logic [DW-1:0]  mem_rdata_i,
  output logic           mem_we_o,
  output logic [DW-1:0]  mem_wdata_o,
  output logic [DW-1:0]  acc_o,
  output logic           carry_o,
  output logic           done_o
);
  uop_t          dec_u;
  alu_op_e       pend_op_q, pend_op_d, alu_op;
  logic          pend_q, pend_d;
  logic [DW-1:0] acc_q, acc_d, wd_q, wd_d, alu_b, alu_res, sh_res, step_res;
  logic          c_q, c_d, we_q, we_d, done_q, done_d, alu_cout, alu_cupd;

  nib_decode u_dec (.word_i(word_i), .uop_o(dec_u));

  assign alu_op = pend_q ? pend_op_q : dec_u.op;
  assign alu_b  = pend_q ? word_i[DW-1:0] : mem_rdata_i;

  nib_alu #(.DW(DW)) u_alu (
    .op_i(alu_op), .a_i(acc_q), .b_i(alu_b), .c_i(c_q),
    .res_o(alu_res), .cout_o(alu_cout), .cupd_o(alu_cupd)
  );

  nib_unary #(.DW(DW)) u_una (
    .acc_i(acc_q), .mem_i(mem_rdata_i), .left_i(dec_u.sh_left),
    .fill_i(dec_u.fill), .dn_i(dec_u.step_dn),
    .shift_o(sh_res), .step_o(step_res)
  );

  always_comb begin
    acc_d     = acc_q;
    c_d       = c_q;
    we_d      = 1'b0;
    wd_d      = wd_q;
    done_d    = 1'b0;
    pend_d    = pend_q;
    pend_op_d = pend_op_q;
    if (valid_i) begin
      if (pend_q) begin
        acc_d  = alu_res;
        if (alu_cupd) c_d = alu_cout;
        done_d = 1'b1;
        pend_d = 1'b0;
      end else begin
        case (dec_u.kind)
          K_MEM: begin
            acc_d  = alu_res;
            if (alu_cupd) c_d = alu_cout;
            if (dec_u.wb) begin
              we_d = 1'b1;
              wd_d = alu_res;
            end
            done_d = 1'b1;
          end
          K_IMM: begin
            pend_d    = 1'b1;
            pend_op_d = dec_u.op;
          end
          K_SHIFT: begin
            acc_d  = sh_res;
            done_d = 1'b1;
          end
          K_STEP: begin
            acc_d  = step_res;
            we_d   = 1'b1;
            wd_d   = step_res;
            done_d = 1'b1;
          end
          default: done_d = 1'b1;  // undefined: retire as no-op
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q     <= '0;
      c_q       <= 1'b0;
      we_q      <= 1'b0;
      wd_q      <= '0;
      done_q    <= 1'b0;
      pend_q    <= 1'b0;
      pend_op_q <= OP_ADC;
    end else begin
      acc_q     <= acc_d;
      c_q       <= c_d;
      we_q      <= we_d;
      wd_q      <= wd_d;
      done_q    <= done_d;
      pend_q    <= pend_d;
      pend_op_q <= pend_op_d;
    end
  end

  assign acc_o       = acc_q;
  assign carry_o     = c_q;
  assign mem_we_o    = we_q;
  assign mem_wdata_o = wd_q;
  assign done_o      = done_q;

  a_r3_we_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> done_o);
  a_r3_wdata_is_acc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_wdata_o == acc_o));
  a_r9_acc_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(acc_o));
  a_r9_carry_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(carry_o));
  a_r6_no_done_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> !done_o);
  a_r11_idle_no_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !done_o);
endmodule

// File: tb/sim_nib_exec_unit.sv
module sim_nib_exec_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic [7:0] word = '0;
  logic [3:0] mem_rd = '0;
  logic       we, carry, done;
  logic [3:0] wd, acc;
  int total = 0;
  int bad = 0;
  logic [3:0] prev_acc;

  always #2 clk = ~clk;

  nib_exec_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .word_i(word),
    .mem_rdata_i(mem_rd), .mem_we_o(we), .mem_wdata_o(wd),
    .acc_o(acc), .carry_o(carry), .done_o(done)
  );

  // {op, imm, mem, exp_acc, exp_c, exp_we, exp_wd}
  localparam int NV = 33;
  localparam logic [25:0] VEC [NV] = '{
    {8'h92,4'h9,4'h0,4'h9,1'b0,1'b0,4'h0},
    {8'h82,4'h0,4'hA,4'h3,1'b1,1'b0,4'h0},
    {8'h80,4'h0,4'h4,4'h8,1'b0,1'b0,4'h0},
    {8'h8B,4'h0,4'h9,4'hF,1'b0,1'b1,4'hF},
    {8'h81,4'h0,4'h2,4'hC,1'b1,1'b0,4'h0},
    {8'h89,4'h0,4'hC,4'h0,1'b1,1'b1,4'h0},
    {8'h94,4'hF,4'h0,4'hF,1'b1,1'b0,4'h0},
    {8'h84,4'h0,4'h3,4'h2,1'b1,1'b0,4'h0},
    {8'h90,4'h5,4'h0,4'h8,1'b0,1'b0,4'h0},
    {8'h93,4'h3,4'h0,4'h5,1'b1,1'b0,4'h0},
    {8'h91,4'h7,4'h0,4'hE,1'b0,1'b0,4'h0},
    {8'h95,4'h6,4'h0,4'h6,1'b0,1'b0,4'h0},
    {8'h97,4'h9,4'h0,4'hF,1'b0,1'b0,4'h0},
    {8'h96,4'h5,4'h0,4'hA,1'b0,1'b0,4'h0},
    {8'h8D,4'h0,4'h6,4'h2,1'b0,1'b1,4'h2},
    {8'h87,4'h0,4'h5,4'h7,1'b0,1'b0,4'h0},
    {8'h8E,4'h0,4'h3,4'h4,1'b0,1'b1,4'h4},
    {8'h8A,4'h0,4'hC,4'h0,1'b1,1'b1,4'h0},
    {8'h88,4'h0,4'h7,4'h8,1'b0,1'b1,4'h8},
    {8'h8C,4'h0,4'h9,4'h1,1'b0,1'b1,4'h1},
    {8'h19,4'h0,4'h0,4'h8,1'b0,1'b0,4'h0},
    {8'h18,4'h0,4'h0,4'h4,1'b0,1'b0,4'h0},
    {8'h1B,4'h0,4'h0,4'h9,1'b0,1'b0,4'h0},
    {8'h1A,4'h0,4'h0,4'h2,1'b0,1'b0,4'h0},
    {8'h98,4'h0,4'hF,4'h0,1'b0,1'b1,4'h0},
    {8'h99,4'h0,4'h0,4'hF,1'b0,1'b1,4'hF},
    {8'h86,4'h0,4'hF,4'h0,1'b0,1'b0,4'h0},
    {8'h83,4'h0,4'h0,4'h0,1'b1,1'b0,4'h0},
    {8'h85,4'h0,4'h0,4'h0,1'b1,1'b0,4'h0},
    {8'h00,4'h0,4'h5,4'h0,1'b1,1'b0,4'h0},
    {8'h9A,4'h0,4'h5,4'h0,1'b1,1'b0,4'h0},
    {8'h98,4'h0,4'h7,4'h8,1'b1,1'b1,4'h8},
    {8'h1A,4'h0,4'h0,4'h0,1'b1,1'b0,4'h0}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [7:0] op);
    if (op[7:4] == 4'h8) return op[3] ? "R3" : "R2";
    if (op[7:4] == 4'h9 && !op[3]) return "R6";
    if (op == 8'h98 || op == 8'h99) return "R8";
    if (op[7:2] == 6'b000110) return "R7";
    return "R10";
  endfunction

  task automatic exec(input logic [7:0] op, input logic [3:0] imm, input logic [3:0] mem);
    @(negedge clk);
    word = op; mem_rd = mem; valid = 1'b1;
    if (op[7:4] == 4'h9 && !op[3]) begin
      @(negedge clk);
      chk("R6 mid done", {7'd0, done}, 8'd0);
      chk("R6 mid we", {7'd0, we}, 8'd0);
      chk("R6 mid acc", {4'd0, acc}, {4'd0, prev_acc});
      word = {4'hA, imm};  // high nibble must be ignored
    end
    @(negedge clk);
    valid = 1'b0;
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog act=hung exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 acc", {4'd0, acc}, 8'd0);
    chk("R1 carry", {7'd0, carry}, 8'd0);
    chk("R1 done", {7'd0, done}, 8'd0);
    chk("R1 we", {7'd0, we}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    prev_acc = 4'h0;

    for (int i = 0; i < NV; i++) begin
      logic [7:0] op;
      logic [3:0] imm, mem, ea, ew;
      logic ec, ewe;
      string t;
      {op, imm, mem, ea, ec, ewe, ew} = VEC[i];
      t = tag_of(op);
      exec(op, imm, mem);
      chk({t, " acc"}, {4'd0, acc}, {4'd0, ea});
      chk({t, " R4_R5 carry"}, {7'd0, carry}, {7'd0, ec});
      chk({t, " we"}, {7'd0, we}, {7'd0, ewe});
      if (ewe) chk({t, " wdata"}, {4'd0, wd}, {4'd0, ew});
      chk({t, " R9 done"}, {7'd0, done}, 8'd1);
      prev_acc = ea;
      @(negedge clk);
      chk("R9 done pulse width", {7'd0, done}, 8'd0);
      chk("R9 we pulse width", {7'd0, we}, 8'd0);
    end

    // R11: idle cycles, word toggling with valid low
    word = 8'h82; mem_rd = 4'hF;
    repeat (3) @(negedge clk);
    chk("R11 done", {7'd0, done}, 8'd0);
    chk("R11 acc", {4'd0, acc}, 8'd0);
    chk("R11 carry", {7'd0, carry}, 8'd1);

    // R1: pending first word dropped at reset
    @(negedge clk);
    word = 8'h92; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset acc", {4'd0, acc}, 8'd0);
    chk("R1 reset carry", {7'd0, carry}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    exec(8'h19, 4'h0, 4'h0);
    chk("R1 pend cleared acc", {4'd0, acc}, 8'h08);
    chk("R1 pend cleared done", {7'd0, done}, 8'd1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule